// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block is the digital supervisor of a lithium-ion charge cycle. The analog front end reports its conditions as synchronous one-bit flags:
- adapter present
- shutdown request
- cell below the depletion threshold
- cell below the recharge threshold
- charge current below one tenth of the programmed value
- input current limit active
- thermistor out of range
- timer bypass

A timebase strobe advances the charge timer. The total charge time is `TICKS_TOTAL` strobes, and a quarter window of `TICKS_TOTAL >> 2` strobes is derived from it.

From these inputs the sequencer decides four things:
- whether the power stage may charge
- whether the current reference is cut to ten percent for a depleted cell
- what the open-drain status pin shows
- which state the timer is in

The sequencer handles the following cases:
- A depleted cell is conditioned at reduced current and is abandoned if it stays depleted for a quarter of the charge time.
- A taper below one tenth of the current shortens the remaining time to one quarter window.
- An expired cycle restarts by itself when the cell sags below the recharge threshold.

All outputs are registered. Every output reflects the inputs sampled at the previous rising clock edge.

Top module: `chg_sequencer`

## Requirements
- R1: After reset the outputs read idle: `chargeEn`=0, `trickleEn`=0, `status`=2'b10 (released, high impedance) and `timerState`=2'b00 (reset). The status codes are 2'b00 = pulled low, 2'b01 = weak sink and 2'b10 = released. The timer state codes are 00 = reset, 01 = running, 10 = paused and 11 = stopped.
- R2: From idle, when `adapterOk`=1 and `shutdownReq`=0, the next edge starts a cycle: `chargeEn`=1, `status`=2'b00, `timerState`=2'b01. The timer then counts one per cycle in which `tick`=1.
- R3: While in the main charge phase with `cellLow`=1 and no pause, `trickleEn`=1.
- R4: If `cellLow` is sampled high on `TICKS_TOTAL>>2` consecutive counted ticks in the main phase, the cycle stops with `chargeEn`=0, `status`=2'b10 and `timerState`=2'b11. Any tick with `cellLow`=0 restarts that count. This stop is left only through removal of the adapter, shutdown or reset. `cellBelowRestart` and a recovered cell have no effect on it.
- R5: `thermFault`=1 during a cycle gives `chargeEn`=0 and `timerState`=2'b10, and ticks are not counted. When it clears, charging and counting resume from the held count.
- R6: In the main phase, `currentLow`=1 with `inLimit`=0 and `cellLow`=0 latches the top-off phase: `status`=2'b01, and exactly `TICKS_TOTAL>>2` counted ticks remain before expiry.
- R7: `currentLow` has no effect while `inLimit`=1.
- R8: When `TICKS_TOTAL` ticks have been counted without bypass, the cycle stops: `chargeEn`=0, `status`=2'b10, `timerState`=2'b11.
- R9: In the expired state, `cellBelowRestart`=1 starts a fresh cycle with the full `TICKS_TOTAL` on the next edge.
- R10: `adapterOk`=0 or `shutdownReq`=1 forces the idle outputs of R1 and clears the timer on the next edge. A new cycle starts once the condition clears.
- R11: With `timerDefeat`=1, `status`=2'b00 in every state and the timer never expires; it saturates one tick short of the end. Depleted-cell conditioning and the R4 stop still work. Releasing the bypass with the count saturated expires the cycle on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one counted unit of charge time |
| adapterOk | input | 1 | Input supply present above the battery |
| shutdownReq | input | 1 | Forced shutdown request |
| cellLow | input | 1 | Cell below the depletion threshold |
| cellBelowRestart | input | 1 | Cell below the automatic recharge threshold |
| currentLow | input | 1 | Charge current below one tenth of programmed |
| inLimit | input | 1 | Input current limit loop active |
| thermFault | input | 1 | Thermistor reading out of range |
| timerDefeat | input | 1 | Bypass of the charge timer |
| chargeEn | output | 1 | Power stage enable |
| trickleEn | output | 1 | Ten percent current select |
| status | output | 2 | Status pin code (00 low, 01 weak sink, 10 released) |
| timerState | output | 2 | 00 reset, 01 running, 10 paused, 11 stopped |

## Verification
Every output is due on the first rising edge after the inputs that cause it. The bench therefore changes inputs on the falling edge and compares outputs on the next falling edge, one edge later. Timed events are counted in ticks sampled at rising edges:
- Expiry appears one edge after the tick that finds `TICKS_TOTAL-1` already counted.
- The start edge from idle counts no tick.
- A top-off reload on an edge overrides the tick sampled there.

The directed checks wait exactly those edge counts: 40 then 41 for a full cycle, 9 then 10 after a reload, and 10 then 11 for a depleted-cell stop. A behavioural model, advanced at each rising edge, is compared on every cycle during both directed and random stimulus.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_TOPOFF,
    ST_DONE,
    ST_LOWFAULT
  } chgState_t;

  // strobes from the sequencing control to the timing datapath
  typedef struct packed {
    logic clrMain;
    logic reloadQuarter;
    logic runMain;
    logic clrLow;
    logic runLow;
  } seqStrobe_t;

  localparam logic [1:0] STAT_LOW  = 2'b00;
  localparam logic [1:0] STAT_WEAK = 2'b01;
  localparam logic [1:0] STAT_OPEN = 2'b10;

  localparam logic [1:0] TS_RESET = 2'b00;
  localparam logic [1:0] TS_RUN   = 2'b01;
  localparam logic [1:0] TS_PAUSE = 2'b10;
  localparam logic [1:0] TS_STOP  = 2'b11;

endpackage

// File: rtl/chg_seq_counter.sv
// Saturating tick counter with clear and load; clear wins over load.
module chg_seq_counter #(
  parameter int W   = 6,
  parameter int SAT = 39
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic         atSat
);
  localparam logic [W-1:0] SAT_VAL = W'(SAT);

  logic [W-1:0] value;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (load) begin
      value <= loadVal;
    end else if (inc && (value != SAT_VAL)) begin
      value <= value + 1'b1;
    end
  end

  assign atSat = (value == SAT_VAL);
endmodule

// File: rtl/chg_seq_datapath.sv
// Charge-time counter and depleted-cell window counter.
// TICKS_TOTAL must be at least 4 so the quarter window is non-empty.
module chg_seq_datapath
  import chg_seq_pkg::*;
#(
  parameter int TICKS_TOTAL = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  seqStrobe_t strb,
  output logic       mainEnd,
  output logic       lowEnd
);
  localparam int QUARTER = TICKS_TOTAL >> 2;
  localparam int CW      = $clog2(TICKS_TOTAL + 1);
  localparam logic [CW-1:0] RELOAD_VAL = CW'(TICKS_TOTAL - QUARTER);

  chg_seq_counter #(.W(CW), .SAT(TICKS_TOTAL - 1)) uMain (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strb.clrMain),
    .load    (strb.reloadQuarter),
    .loadVal (RELOAD_VAL),
    .inc     (strb.runMain && tick),
    .atSat   (mainEnd)
  );

  chg_seq_counter #(.W(CW), .SAT(QUARTER - 1)) uLow (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strb.clrLow),
    .load    (1'b0),
    .loadVal ('0),
    .inc     (strb.runLow && tick),
    .atSat   (lowEnd)
  );
endmodule

// File: rtl/chg_seq_fsm.sv
// Charge cycle sequencing: next state, strobes and registered outputs.
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       adapterOk,
  input  logic       shutdownReq,
  input  logic       cellLow,
  input  logic       cellBelowRestart,
  input  logic       currentLow,
  input  logic       inLimit,
  input  logic       thermFault,
  input  logic       timerDefeat,
  input  logic       mainEnd,
  input  logic       lowEnd,
  output seqStrobe_t strb,
  output logic       chargeEn,
  output logic       trickleEn,
  output logic [1:0] status,
  output logic [1:0] timerState
);
  chgState_t stateQ, stateNxt;
  logic      active, expireNow, runNxt;
  logic [1:0] statusNxt, tsNxt;

  assign active    = adapterOk && !shutdownReq;
  assign expireNow = tick && mainEnd && !timerDefeat;

  always_comb begin
    stateNxt           = stateQ;
    strb               = '0;
    if (!active) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: stateNxt = ST_CHARGE;
        ST_CHARGE: begin
          if (!thermFault) begin
            if (tick && cellLow && lowEnd) begin
              stateNxt = ST_LOWFAULT;
            end else if (expireNow) begin
              stateNxt = ST_DONE;
            end else if (currentLow && !inLimit && !cellLow) begin
              stateNxt           = ST_TOPOFF;
              strb.reloadQuarter = 1'b1;
            end else begin
              strb.runMain = 1'b1;
            end
          end
        end
        ST_TOPOFF: begin
          if (!thermFault) begin
            if (expireNow) stateNxt = ST_DONE;
            else           strb.runMain = 1'b1;
          end
        end
        ST_DONE:     if (cellBelowRestart) stateNxt = ST_CHARGE;
        ST_LOWFAULT: stateNxt = ST_LOWFAULT;
        default:     stateNxt = ST_IDLE;
      endcase
    end
    runNxt       = (stateNxt == ST_CHARGE) || (stateNxt == ST_TOPOFF);
    strb.clrMain = !runNxt;
    strb.clrLow  = (stateNxt != ST_CHARGE) || !cellLow;
    strb.runLow  = (stateQ == ST_CHARGE) && (stateNxt == ST_CHARGE) &&
                   !thermFault && cellLow;
  end

  always_comb begin
    if (timerDefeat)                 statusNxt = STAT_LOW;
    else if (stateNxt == ST_CHARGE)  statusNxt = STAT_LOW;
    else if (stateNxt == ST_TOPOFF)  statusNxt = STAT_WEAK;
    else                             statusNxt = STAT_OPEN;

    if (stateNxt == ST_IDLE)         tsNxt = TS_RESET;
    else if (runNxt)                 tsNxt = thermFault ? TS_PAUSE : TS_RUN;
    else                             tsNxt = TS_STOP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      chargeEn   <= 1'b0;
      trickleEn  <= 1'b0;
      status     <= STAT_OPEN;
      timerState <= TS_RESET;
    end else begin
      stateQ     <= stateNxt;
      chargeEn   <= runNxt && !thermFault;
      trickleEn  <= (stateNxt == ST_CHARGE) && !thermFault && cellLow;
      status     <= statusNxt;
      timerState <= tsNxt;
    end
  end
endmodule

// File: rtl/chg_sequencer.sv
module chg_sequencer
  import chg_seq_pkg::*;
#(
  parameter int TICKS_TOTAL = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       adapterOk,
  input  logic       shutdownReq,
  input  logic       cellLow,
  input  logic       cellBelowRestart,
  input  logic       currentLow,
  input  logic       inLimit,
  input  logic       thermFault,
  input  logic       timerDefeat,
  output logic       chargeEn,
  output logic       trickleEn,
  output logic [1:0] status,
  output logic [1:0] timerState
);
  seqStrobe_t strb;
  logic       mainEnd, lowEnd;

  chg_seq_fsm uFsm (
    .clk              (clk),
    .rstN             (rstN),
    .tick             (tick),
    .adapterOk        (adapterOk),
    .shutdownReq      (shutdownReq),
    .cellLow          (cellLow),
    .cellBelowRestart (cellBelowRestart),
    .currentLow       (currentLow),
    .inLimit          (inLimit),
    .thermFault       (thermFault),
    .timerDefeat      (timerDefeat),
    .mainEnd          (mainEnd),
    .lowEnd           (lowEnd),
    .strb             (strb),
    .chargeEn         (chargeEn),
    .trickleEn        (trickleEn),
    .status           (status),
    .timerState       (timerState)
  );

  chg_seq_datapath #(.TICKS_TOTAL(TICKS_TOTAL)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .strb    (strb),
    .mainEnd (mainEnd),
    .lowEnd  (lowEnd)
  );
endmodule

// File: rtl/chg_sequencer_chk.sv
module chg_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       adapterOk,
  input logic       shutdownReq,
  input logic       thermFault,
  input logic       timerDefeat,
  input logic       chargeEn,
  input logic       trickleEn,
  input logic [1:0] status,
  input logic [1:0] timerState
);
  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!adapterOk || shutdownReq) |=> (!chargeEn && !trickleEn && timerState == 2'b00)); // R10

  AST_PAUSE_STOPS_CHARGE: assert property (@(posedge clk) disable iff (!rstN)
    thermFault |=> !chargeEn); // R5

  AST_BYPASS_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    timerDefeat |=> (status == 2'b00)); // R11

  AST_TRICKLE_ONLY_CHARGING: assert property (@(posedge clk) disable iff (!rstN)
    trickleEn |-> (chargeEn && timerState == 2'b01)); // R3

  AST_STOPPED_NO_CHARGE: assert property (@(posedge clk) disable iff (!rstN)
    (timerState == 2'b11) |-> !chargeEn); // R8

  AST_STATUS_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b11); // R1
endmodule

bind chg_sequencer chg_sequencer_chk uChk (.*);

// File: tb/sim_chg_sequencer.sv
`timescale 1ns/1ps
module sim_chg_sequencer;
  localparam int T = 40;
  localparam int Q = T / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, adapterOk = 1'b0, shutdownReq = 1'b0, cellLow = 1'b0;
  logic cellBelowRestart = 1'b0, currentLow = 1'b0, inLimit = 1'b0;
  logic thermFault = 1'b0, timerDefeat = 1'b0;
  logic chargeEn, trickleEn;
  logic [1:0] status, timerState;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chg_sequencer #(.TICKS_TOTAL(T)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .adapterOk(adapterOk),
    .shutdownReq(shutdownReq), .cellLow(cellLow),
    .cellBelowRestart(cellBelowRestart), .currentLow(currentLow),
    .inLimit(inLimit), .thermFault(thermFault), .timerDefeat(timerDefeat),
    .chargeEn(chargeEn), .trickleEn(trickleEn), .status(status),
    .timerState(timerState)
  );

  // behavioural reference: 0 idle, 1 charging, 2 top-off, 3 expired, 4 depleted fault
  int mSt = 0, mCnt = 0, mLow = 0;
  bit eCharge = 0, eTrickle = 0;
  logic [1:0] eStatus = 2'b10, eTs = 2'b00;
  string mTag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mLow = 0;
      eCharge = 0; eTrickle = 0; eStatus = 2'b10; eTs = 2'b00; mTag = "R1";
    end else begin
      int nx;
      bit reload;
      nx = mSt; reload = 0; mTag = "R2";
      if (!adapterOk || shutdownReq) begin
        nx = 0; mTag = "R10";
      end else if (mSt == 0) begin
        nx = 1;
      end else if (mSt == 1 || mSt == 2) begin
        if (thermFault) mTag = "R5";
        else if (mSt == 1 && tick && cellLow && mLow == Q - 1) begin nx = 4; mTag = "R4"; end
        else if (tick && mCnt == T - 1 && !timerDefeat) begin nx = 3; mTag = "R8"; end
        else if (mSt == 1 && currentLow && !cellLow) begin
          if (inLimit) mTag = "R7";
          else begin nx = 2; reload = 1; mTag = "R6"; end
        end
      end else if (mSt == 3 && cellBelowRestart) begin
        nx = 1; mTag = "R9";
      end
      if (nx != 1 && nx != 2) mCnt = 0;
      else if (reload) mCnt = T - Q;
      else if ((mSt == 1 || mSt == 2) && !thermFault && tick && mCnt < T - 1) mCnt++;
      if (nx != 1 || !cellLow) mLow = 0;
      else if (mSt == 1 && !thermFault && tick) mLow++;
      eCharge  = (nx == 1 || nx == 2) && !thermFault;
      eTrickle = (nx == 1) && !thermFault && cellLow;
      eStatus  = timerDefeat ? 2'b00 : (nx == 1) ? 2'b00 : (nx == 2) ? 2'b01 : 2'b10;
      eTs      = (nx == 0) ? 2'b00 : (nx == 1 || nx == 2) ? (thermFault ? 2'b10 : 2'b01) : 2'b11;
      if (mTag == "R2" && timerDefeat) mTag = "R11";
      if (mTag == "R2" && eTrickle) mTag = "R3";
      mSt = nx;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if ({chargeEn, trickleEn, status, timerState} !== {eCharge, eTrickle, eStatus, eTs}) begin
      errors++;
      $display("FAIL %s cycle compare: actual en=%b tr=%b st=%b ts=%b expected en=%b tr=%b st=%b ts=%b",
               mTag, chargeEn, trickleEn, status, timerState, eCharge, eTrickle, eStatus, eTs);
    end
  end

  task automatic chk(input string req, input bit en, input bit tr,
                     input logic [1:0] st, input logic [1:0] ts);
    checks++;
    if (chargeEn !== en || trickleEn !== tr || status !== st || timerState !== ts) begin
      errors++;
      $display("FAIL %s: actual en=%b tr=%b st=%b ts=%b expected en=%b tr=%b st=%b ts=%b",
               req, chargeEn, trickleEn, status, timerState, en, tr, st, ts);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1", 0, 0, 2'b10, 2'b00);
    rstN = 1'b1;
    cyc(1);
    chk("R1", 0, 0, 2'b10, 2'b00);
    // R2: start, tick every cycle from here
    adapterOk = 1'b1; tick = 1'b1;
    cyc(1);
    chk("R2", 1, 0, 2'b00, 2'b01);
    // R3: depleted cell conditioning
    cellLow = 1'b1;
    cyc(1);
    chk("R3", 1, 1, 2'b00, 2'b01);
    cyc(2);
    cellLow = 1'b0;
    cyc(1);
    chk("R3", 1, 0, 2'b00, 2'b01);
    // R5: thermistor pause and resume
    thermFault = 1'b1;
    cyc(5);
    chk("R5", 0, 0, 2'b00, 2'b10);
    thermFault = 1'b0;
    cyc(1);
    chk("R5", 1, 0, 2'b00, 2'b01);
    // R10: shutdown resets, then a clean full cycle
    shutdownReq = 1'b1;
    cyc(1);
    chk("R10", 0, 0, 2'b10, 2'b00);
    shutdownReq = 1'b0;
    cyc(40);
    chk("R8", 1, 0, 2'b00, 2'b01);
    cyc(1);
    chk("R8", 0, 0, 2'b10, 2'b11);
    cyc(3);
    chk("R8", 0, 0, 2'b10, 2'b11);
    // R9: automatic restart
    cellBelowRestart = 1'b1;
    cyc(1);
    chk("R9", 1, 0, 2'b00, 2'b01);
    cellBelowRestart = 1'b0;
    cyc(4);
    // R7: taper ignored under input limit
    currentLow = 1'b1; inLimit = 1'b1;
    cyc(1);
    chk("R7", 1, 0, 2'b00, 2'b01);
    inLimit = 1'b0;
    cyc(1);
    chk("R6", 1, 0, 2'b01, 2'b01);
    currentLow = 1'b0;
    cyc(9);
    chk("R6", 1, 0, 2'b01, 2'b01);
    cyc(1);
    chk("R6", 0, 0, 2'b10, 2'b11);
    // R4: depleted cell fault after a quarter window
    adapterOk = 1'b0;
    cyc(1);
    chk("R10", 0, 0, 2'b10, 2'b00);
    adapterOk = 1'b1; cellLow = 1'b1;
    cyc(10);
    chk("R4", 1, 1, 2'b00, 2'b01);
    cyc(1);
    chk("R4", 0, 0, 2'b10, 2'b11);
    cellLow = 1'b0; cellBelowRestart = 1'b1;
    cyc(5);
    chk("R4", 0, 0, 2'b10, 2'b11);
    cellBelowRestart = 1'b0; shutdownReq = 1'b1;
    cyc(1);
    chk("R10", 0, 0, 2'b10, 2'b00);
    shutdownReq = 1'b0;
    cyc(1);
    chk("R10", 1, 0, 2'b00, 2'b01);
    // R11: timer bypass
    timerDefeat = 1'b1;
    cyc(60);
    chk("R11", 1, 0, 2'b00, 2'b01);
    timerDefeat = 1'b0;
    cyc(1);
    chk("R11", 0, 0, 2'b10, 2'b11);
    // random phase, compared against the model every cycle
    rstN = 1'b0;
    cyc(1);
    chk("R1", 0, 0, 2'b10, 2'b00);
    rstN = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom_range(0, 1) == 1);
      adapterOk = ($urandom_range(0, 199) != 0);
      shutdownReq = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 29) == 0) cellLow = ~cellLow;
      if ($urandom_range(0, 39) == 0) cellBelowRestart = ~cellBelowRestart;
      currentLow = ($urandom_range(0, 59) == 0);
      if ($urandom_range(0, 19) == 0) inLimit = ~inLimit;
      if ($urandom_range(0, 49) == 0) thermFault = ~thermFault;
      if ($urandom_range(0, 299) == 0) timerDefeat = ~timerDefeat;
      cyc(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule